// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Initialization

This block decides when an asynchronous DRAM must receive a CAS-before-RAS refresh cycle, and it drives the strobes for that cycle while it owns the memory bus. Out of reset it holds off all activity for a programmable power-up pause. It then asks for a burst of initialization refresh cycles. Only after the last of these has completed does it declare the memory ready for normal accesses.

From then on, a free-running interval timer raises one distributed refresh request per interval. A request waits in a pending flag until the access arbiter grants the bus. A grant starts a strobe sequence with four parts: precharge, CAS setup, CAS and RAS both low, and RAS low alone. A one-cycle done pulse hands the bus back. The refresh type needs no row address, so address, write enable and output enable are left to the access controller.

If a second interval expires while a request is still waiting, the two requests merge into one and a sticky overflow flag records the lost refresh. All timings are counted in clock cycles and set by parameters.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is held and just after it: refReq, refDone, busOwn, initDone and overflow are 0, and rasN, ucasN and lcasN are 1.
- R2: refReq first rises exactly PAUSE_CYC clock edges after reset is released, and it stays 0 before that.
- R3: After the pause, exactly INIT_CYCLES refresh requests are raised back to back. Each one after the first appears in the cycle that follows the previous done pulse. No other request is raised before initialization completes.
- R4: The edge that accepts a grant starts the strobe sequence. The sequence is RP_CYC cycles with both strobes high, then CSR_CYC cycles with only CAS low, then CHR_CYC cycles with both low, then RAS_LOW_CYC-CHR_CYC cycles with only RAS low. busOwn is 1 throughout.
- R5: CAS is the same on ucasN and lcasN. It falls before RAS falls and is still low in the cycle in which RAS falls.
- R6: refReq is 1 only when a request is pending and no sequence is running. After the last RAS-low cycle comes one cycle with refDone=1, busOwn=0 and both strobes high.
- R7: initDone is 0 until the done cycle of the last initialization refresh, becomes 1 in that cycle, and never returns to 0.
- R8: Once initDone is 1, a distributed request is raised every INTERVAL_CYC edges, counted from the edge that set initDone. The timer runs freely, whenever the requests are served.
- R9: A pending request holds refReq high until it is granted. An interval that expires while a sequence runs leaves a request pending, and refReq rises after that sequence's done cycle.
- R10: If an interval expires while a request is still waiting for its grant, overflow becomes 1 and stays 1, and only one request remains pending.
- R11: refGrant has no effect while refReq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refGrant | input | 1 | Arbiter grants the bus to the pending refresh |
| refReq | output | 1 | A refresh is pending and the scheduler is idle |
| refDone | output | 1 | One-cycle pulse: refresh finished, bus released |
| busOwn | output | 1 | Scheduler drives the DRAM strobes |
| rasN | output | 1 | Row strobe, active low |
| ucasN | output | 1 | Upper-byte column strobe, active low |
| lcasN | output | 1 | Lower-byte column strobe, active low |
| initDone | output | 1 | Power-up pause and initialization burst complete |
| overflow | output | 1 | Sticky: a refresh interval was lost |

## Verification
The bench builds the block with a 20-cycle pause, a 30-cycle interval, eight initialization cycles, and phase lengths of 2, 1 and 2 cycles with a 4-cycle RAS-low width. At these values the whole pause, all eight initialization sequences and nine refresh intervals run in a few hundred cycles. Every cycle of every strobe sequence is compared with the phase boundaries computed from those lengths. The grant delay is swept from immediate to late enough that the sequence spans a timer expiry. The overflow merge and a grant given with no request are also reached.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_PRE,
    ST_SETUP,
    ST_HOLD,
    ST_RASON,
    ST_DONE
  } seqState_t;

  // Strobes from control to the counter datapath
  typedef struct packed {
    seqState_t phaseSel;
    logic      pauseRun;
    logic      phaseRun;
    logic      initBump;
    logic      intervalRun;
  } ctrlStrobe_t;

  // Terminal-count flags back from the datapath
  typedef struct packed {
    logic pauseLast;
    logic phaseLast;
    logic initFinal;
    logic intervalTick;
  } dpStatus_t;

endpackage

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int INTERVAL_CYC = 1560,
  parameter int INIT_CYCLES  = 8,
  parameter int RP_CYC       = 4,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 1,
  parameter int RAS_LOW_CYC  = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);

  localparam int RASON_CYC = RAS_LOW_CYC - CHR_CYC;
  localparam int MAX_A     = (RP_CYC > CSR_CYC) ? RP_CYC : CSR_CYC;
  localparam int MAX_B     = (CHR_CYC > RASON_CYC) ? CHR_CYC : RASON_CYC;
  localparam int MAX_PH    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int PHW       = $clog2(MAX_PH + 1);
  localparam int PSW       = $clog2(PAUSE_CYC + 1);
  localparam int IVW       = $clog2(INTERVAL_CYC + 1);
  localparam int INW       = $clog2(INIT_CYCLES + 1);

  logic [PSW-1:0] pauseCnt;
  logic [PHW-1:0] phaseCnt;
  logic [PHW-1:0] phaseLen;
  logic [IVW-1:0] intervalCnt;
  logic [INW-1:0] initCnt;

  // Phase length chosen by the sequence step being timed
  always_comb begin
    unique case (strobe.phaseSel)
      ST_PRE:   phaseLen = PHW'(RP_CYC);
      ST_SETUP: phaseLen = PHW'(CSR_CYC);
      ST_HOLD:  phaseLen = PHW'(CHR_CYC);
      ST_RASON: phaseLen = PHW'(RASON_CYC);
      default:  phaseLen = PHW'(1);
    endcase
  end

  assign status.pauseLast    = strobe.pauseRun && (pauseCnt == PSW'(PAUSE_CYC - 1));
  assign status.phaseLast    = strobe.phaseRun && (phaseCnt == phaseLen - PHW'(1));
  assign status.initFinal    = (initCnt == INW'(INIT_CYCLES - 1));
  assign status.intervalTick = strobe.intervalRun && (intervalCnt == IVW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pauseCnt <= '0;
    end else if (strobe.pauseRun && !status.pauseLast) begin
      pauseCnt <= pauseCnt + PSW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (!strobe.phaseRun || status.phaseLast) begin
      phaseCnt <= '0;
    end else begin
      phaseCnt <= phaseCnt + PHW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (strobe.intervalRun) begin
      intervalCnt <= status.intervalTick ? '0 : intervalCnt + IVW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt <= '0;
    end else if (strobe.initBump) begin
      initCnt <= initCnt + INW'(1);
    end
  end

  // R4: the phase counter never passes the length of the step it times
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.phaseRun |-> (phaseCnt < phaseLen));

  // R3: the burst counter never bumps past the configured burst length
  init_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.initBump |-> (initCnt < INW'(INIT_CYCLES)));

endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        refGrant,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        refReq,
  output logic        refDone,
  output logic        busOwn,
  output logic        rasN,
  output logic        casN,
  output logic        initDone,
  output logic        overflow
);

  seqState_t state, stateNext;
  logic pending, pendingNext;
  logic overflowNext, initDoneNext;
  logic take, enterDone, seqActive;

  assign take      = (state == ST_IDLE) && pending && refGrant;
  assign enterDone = (state == ST_RASON) && status.phaseLast;
  assign seqActive = (state == ST_PRE) || (state == ST_SETUP) ||
                     (state == ST_HOLD) || (state == ST_RASON);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_PAUSE: if (status.pauseLast) stateNext = ST_IDLE;
      ST_IDLE:  if (take)             stateNext = ST_PRE;
      ST_PRE:   if (status.phaseLast) stateNext = ST_SETUP;
      ST_SETUP: if (status.phaseLast) stateNext = ST_HOLD;
      ST_HOLD:  if (status.phaseLast) stateNext = ST_RASON;
      ST_RASON: if (status.phaseLast) stateNext = ST_DONE;
      ST_DONE:                        stateNext = ST_IDLE;
      default:                        stateNext = ST_PAUSE;
    endcase
  end

  always_comb begin
    pendingNext = (pending && !take) ||
                  ((state == ST_PAUSE) && status.pauseLast) ||
                  (enterDone && !initDone && !status.initFinal) ||
                  status.intervalTick;
    overflowNext = overflow || (status.intervalTick && pending && !take);
    initDoneNext = initDone || (enterDone && status.initFinal);
  end

  always_comb begin
    strobe.phaseSel    = state;
    strobe.pauseRun    = (state == ST_PAUSE);
    strobe.phaseRun    = seqActive;
    strobe.initBump    = enterDone && !initDone;
    strobe.intervalRun = initDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_PAUSE;
      pending  <= 1'b0;
      overflow <= 1'b0;
      initDone <= 1'b0;
      refReq   <= 1'b0;
      refDone  <= 1'b0;
      busOwn   <= 1'b0;
      rasN     <= 1'b1;
      casN     <= 1'b1;
    end else begin
      state    <= stateNext;
      pending  <= pendingNext;
      overflow <= overflowNext;
      initDone <= initDoneNext;
      refReq   <= pendingNext && (stateNext == ST_IDLE);
      refDone  <= (stateNext == ST_DONE);
      busOwn   <= (stateNext == ST_PRE) || (stateNext == ST_SETUP) ||
                  (stateNext == ST_HOLD) || (stateNext == ST_RASON);
      rasN     <= !((stateNext == ST_HOLD) || (stateNext == ST_RASON));
      casN     <= !((stateNext == ST_SETUP) || (stateNext == ST_HOLD));
    end
  end

  // R5
  cas_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> ($past(casN) == 1'b0));

  // R5
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> !casN);

  // R6
  req_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> (!busOwn && !refDone));

  // R4
  ras_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || !casN) |-> busOwn);

  // R7
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(initDone) |-> initDone);

  // R10
  no_overflow_early_chk: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> !overflow);

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(overflow) |-> overflow);

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refsched_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int INTERVAL_CYC = 1560,
  parameter int INIT_CYCLES  = 8,
  parameter int RP_CYC       = 4,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 1,
  parameter int RAS_LOW_CYC  = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  output logic refReq,
  output logic refDone,
  output logic busOwn,
  output logic rasN,
  output logic ucasN,
  output logic lcasN,
  output logic initDone,
  output logic overflow
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;
  logic        casN;

  refsched_dp #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INTERVAL_CYC(INTERVAL_CYC),
    .INIT_CYCLES (INIT_CYCLES),
    .RP_CYC      (RP_CYC),
    .CSR_CYC     (CSR_CYC),
    .CHR_CYC     (CHR_CYC),
    .RAS_LOW_CYC (RAS_LOW_CYC)
  ) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .status(status)
  );

  refsched_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .refGrant(refGrant),
    .status  (status),
    .strobe  (strobe),
    .refReq  (refReq),
    .refDone (refDone),
    .busOwn  (busOwn),
    .rasN    (rasN),
    .casN    (casN),
    .initDone(initDone),
    .overflow(overflow)
  );

  // Both byte strobes fall together so the refresh is selected whatever the OR of them
  assign ucasN = casN;
  assign lcasN = casN;

endmodule

// File: tb/test_refresh_scheduler.sv
module test_refresh_scheduler;

  localparam int P   = 20;
  localparam int IV  = 30;
  localparam int NI  = 8;
  localparam int RP  = 2;
  localparam int CSR = 1;
  localparam int CHR = 2;
  localparam int RL  = 4;
  localparam int T   = RP + CSR + RL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic refReq, refDone, busOwn, rasN, ucasN, lcasN, initDone, overflow;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int lastG = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  refresh_scheduler #(
    .PAUSE_CYC(P), .INTERVAL_CYC(IV), .INIT_CYCLES(NI),
    .RP_CYC(RP), .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_LOW_CYC(RL)
  ) i_refresh_scheduler (
    .clk(clk), .rstN(rstN), .refGrant(refGrant),
    .refReq(refReq), .refDone(refDone), .busOwn(busOwn),
    .rasN(rasN), .ucasN(ucasN), .lcasN(lcasN),
    .initDone(initDone), .overflow(overflow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // Advance to the negedge after edge 'target', checking refReq on the way
  task automatic runTo(input int target, input logic expReq, input string tag);
    while (cyc < target) begin
      @(negedge clk);
      if (cyc < target) chk(tag, refReq, expReq);
    end
  endtask

  // Called at a negedge where refReq is 1; grants and checks every cycle
  task automatic serveOne(input logic expInit, input logic expReqAfter);
    chk("R6 req before grant", refReq, 1);
    refGrant = 1'b1;
    lastG = cyc + 1;
    for (int i = 0; i <= T + 1; i++) begin
      @(negedge clk);
      if (i == 0) refGrant = 1'b0;
      chk("R5 byte strobes equal", ucasN, lcasN);
      if (i < RP) begin
        chk("R4 precharge bus", busOwn, 1); chk("R4 precharge ras", rasN, 1);
        chk("R4 precharge cas", ucasN, 1);  chk("R6 req low busy", refReq, 0);
      end else if (i < RP + CSR) begin
        chk("R5 setup cas", ucasN, 0); chk("R5 setup ras", rasN, 1);
        chk("R4 setup bus", busOwn, 1);
      end else if (i < RP + CSR + CHR) begin
        chk("R5 hold cas", ucasN, 0); chk("R4 hold ras", rasN, 0);
        chk("R4 hold bus", busOwn, 1);
      end else if (i < T) begin
        chk("R4 ras-only cas", ucasN, 1); chk("R4 ras-only ras", rasN, 0);
        chk("R4 ras-only bus", busOwn, 1); chk("R6 no done yet", refDone, 0);
      end else if (i == T) begin
        chk("R6 done pulse", refDone, 1); chk("R6 bus released", busOwn, 0);
        chk("R6 done ras", rasN, 1); chk("R6 done cas", lcasN, 1);
        chk("R7 initDone at done", initDone, expInit);
      end else begin
        chk("R6 done one cycle", refDone, 0);
        chk("R3 R9 next request", refReq, expReqAfter);
      end
    end
  endtask

  initial begin
    int e;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 refReq", refReq, 0);   chk("R1 refDone", refDone, 0);
    chk("R1 busOwn", busOwn, 0);   chk("R1 rasN", rasN, 1);
    chk("R1 ucasN", ucasN, 1);     chk("R1 lcasN", lcasN, 1);
    chk("R1 initDone", initDone, 0); chk("R1 overflow", overflow, 0);
    rstN = 1'b1;

    // R2 pause
    runTo(P, 1'b0, "R2 no request in pause");
    chk("R2 request after pause", refReq, 1);
    chk("R1 bus idle in pause", busOwn, 0);

    // R3 initialization burst, R7 init done on the last one
    for (int k = 0; k < NI; k++) begin
      chk("R7 initDone low in burst", initDone, 0);
      serveOne(k == NI - 1, k < NI - 1);
    end
    e = lastG + T;
    chk("R7 initDone stays", initDone, 1);

    // R8 first interval
    runTo(e + IV, 1'b0, "R8 no request before interval");
    chk("R8 request at interval", refReq, 1);
    serveOne(1'b1, 1'b0);

    // R8 R9 sweep of grant delay, timer free-running
    for (int m = 2; m <= 4; m++) begin
      runTo(e + m * IV, 1'b0, "R8 quiet between intervals");
      chk("R8 request at interval", refReq, 1);
      for (int d = 0; d < (m - 2) * 3; d++) begin
        @(negedge clk);
        chk("R9 request held until grant", refReq, 1);
      end
      serveOne(1'b1, 1'b0);
    end

    // R9 interval expiring while a sequence runs
    runTo(e + 5 * IV, 1'b0, "R8 quiet");
    chk("R8 request at interval", refReq, 1);
    runTo(e + 6 * IV - 4, 1'b1, "R9 held");
    serveOne(1'b1, 1'b1);
    chk("R10 no overflow when busy", overflow, 0);
    serveOne(1'b1, 1'b0);

    // R10 overflow
    runTo(e + 7 * IV, 1'b0, "R8 quiet");
    chk("R8 request at interval", refReq, 1);
    runTo(e + 8 * IV - 1, 1'b1, "R9 held");
    chk("R10 overflow before second expiry", overflow, 0);
    @(negedge clk);
    chk("R10 overflow set", overflow, 1);
    chk("R10 request still up", refReq, 1);
    serveOne(1'b1, 1'b0);
    chk("R10 merged to one request", refReq, 0);
    chk("R10 overflow sticky", overflow, 1);

    // R11 grant without request
    refGrant = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R11 bus untouched", busOwn, 0);
      chk("R11 ras untouched", rasN, 1);
      chk("R11 cas untouched", ucasN, 1);
      chk("R11 no done", refDone, 0);
    end
    refGrant = 1'b0;
    runTo(e + 9 * IV, 1'b0, "R11 no request from stray grant");
    chk("R8 request at interval", refReq, 1);
    chk("R10 overflow still set", overflow, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired cyc=%0d actual=running expected=finished", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule